// File: doc/BRIEF.md
# Dual-Channel Converter Serial Output Formatter

This block turns the parallel results of a two-channel converter into serial bit streams. Each channel delivers a 12-bit sample and an out-of-range flag. For every word period the block captures one word per channel and shifts it out most significant bit first. It can use one data lane per channel, or two lanes that each carry half the bits at half the rate. A bit clock output changes level on every bit, so the receiver captures data on both of its edges. A frame output marks where each word begins.

The block runs on one clock at the lane bit rate. In two-lane mode the low lane can carry its word aligned with the high lane, or delayed by half a lane word. Either channel can be powered down. The data can be replaced by a fixed test word or by a test word loaded from a register. A serial-control enable input decides which source of settings the block obeys: the direct control pins, or the register fields supplied by a separate register decoder.

Top module: `adc_serial_formatter`

## Requirements
- R1: While reset is active, every data lane, the bit clock, the frame marker and both range flags are 0.
- R2: In single-lane mode, each word takes 12 cycles on the high lane, D11 first and D0 last. D0 of a sample word is always 0, and the low lane stays 0.
- R3: In two-lane mode, each word takes 6 cycles. The high lane carries D11, D9, D7, D5, D3, D1 and the low lane carries D10, D8, D6, D4, D2, D0, in that order.
- R4: In two-lane mode with the align control at 1, the low lane starts its word in the same cycle as the high lane. With the align control at 0, the low lane runs 3 cycles behind. In single-lane mode the align control has no effect.
- R5: The bit clock changes level every cycle and is 1 during the first bit of every word.
- R6: The frame marker is 1 for the first half of each word period (6 cycles in single-lane mode, 3 in two-lane mode) and 0 for the rest. It rises with the first bit of the word.
- R7: With the test pin at 1 (serial-control enable at 0), both channels send 101001100011 (12'hA63), D0 included.
- R8: With serial-control enable at 1, the register fields set the lane mode, alignment, power-down and test mode. In test mode, custom select at 1 sends the register pattern unchanged and custom select at 0 sends 12'hA63.
- R9: With serial-control enable at 1, the power-down, lane, align and test pins have no effect.
- R10: A powered-down channel drives both of its lanes and its range flag to 0, and the other channel is unaffected.
- R11: A range flag shows the flag captured with the current word and changes only at the start of a word.
- R12: Inputs and settings are captured only at a word boundary. A change made during a word takes effect with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane bit-rate clock |
| rstN | input | 1 | Active-low reset |
| sampleA | input | 12 | Channel A conversion result |
| rangeErrA | input | 1 | Channel A out-of-range flag from the converter |
| sampleB | input | 12 | Channel B conversion result |
| rangeErrB | input | 1 | Channel B out-of-range flag from the converter |
| serCtlEn | input | 1 | 1 selects register fields, 0 selects direct pins |
| pinPdA | input | 1 | Direct pin: power down channel A |
| pinPdB | input | 1 | Direct pin: power down channel B |
| pinSingleLane | input | 1 | Direct pin: 1 single lane, 0 two lanes |
| pinAlign | input | 1 | Direct pin: 1 aligned lanes, 0 staggered lanes |
| pinTest | input | 1 | Direct pin: send the fixed test word |
| regPdA | input | 1 | Register field: power down channel A |
| regPdB | input | 1 | Register field: power down channel B |
| regSingleLane | input | 1 | Register field: lane mode |
| regAlign | input | 1 | Register field: lane alignment |
| regTestEn | input | 1 | Register field: test mode |
| regCustomSel | input | 1 | Register field: use custom test word |
| regCustomPat | input | 12 | Register field: custom test word |
| laneHiA | output | 1 | Channel A high lane (used in both modes) |
| laneLoA | output | 1 | Channel A low lane (two-lane mode only) |
| laneHiB | output | 1 | Channel B high lane |
| laneLoB | output | 1 | Channel B low lane |
| bitClkOut | output | 1 | Bit clock, one level change per bit |
| frameOut | output | 1 | Word frame marker |
| rangeOutA | output | 1 | Channel A range flag for the current word |
| rangeOutB | output | 1 | Channel B range flag for the current word |

## Verification
If the bit counter or the latched mode is wrong, the frame marker and bit clock fall out of step within one word period, at most 12 cycles. A wrong load selection shows up as a wrong reconstructed word during the first word after the change. A fault in the stagger delay line corrupts the low-lane bits 3 cycles into the word. A power-down or range register that is out of step with the word leaves a lane or flag high in the first cycle of a word that should be quiet.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  localparam int NUM_CH = 2;

  // Settings that take effect when a word is loaded
  typedef struct packed {
    logic [NUM_CH-1:0] pd;
    logic              singleLane;
    logic              useTest;
    logic              useCustom;
  } fmtCfg_t;

  // How the low lane is driven during the current word
  typedef enum logic [1:0] {
    LO_OFF     = 2'd0,
    LO_DIRECT  = 2'd1,
    LO_DELAYED = 2'd2
  } loMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadWord;
    fmtCfg_t           nextCfg;
    logic [NUM_CH-1:0] curPd;
    loMode_e           curLo;
  } fmtStrobe_t;
endpackage

// File: rtl/fmt_control.sv
module fmt_control
  import adcfmt_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serCtlEn,
  input  logic [NUM_CH-1:0] pinPd,
  input  logic              pinSingleLane,
  input  logic              pinAlign,
  input  logic              pinTest,
  input  logic [NUM_CH-1:0] regPd,
  input  logic              regSingleLane,
  input  logic              regAlign,
  input  logic              regTestEn,
  input  logic              regCustomSel,
  output fmtStrobe_t        ctlStrobe,
  output logic              bitClk,
  output logic              frameHigh
);
  localparam int LANE_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_SINGLE = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_DUAL   = CNT_W'(LANE_W - 1);
  localparam logic [CNT_W-1:0] HALF_SINGLE = CNT_W'(WORD_W / 2);
  localparam logic [CNT_W-1:0] HALF_DUAL   = CNT_W'(LANE_W / 2);

  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  lastIdx;
  logic              wordEnd;
  logic              curSingle;
  logic              curStagger;
  logic [NUM_CH-1:0] curPd;
  logic              clkQ;

  logic [NUM_CH-1:0] selPd;
  logic              selSingle;
  logic              selAlign;
  logic              selTest;
  logic              selCustom;
  logic              selStagger;

  // Source select: register fields override the direct pins
  always_comb begin
    if (serCtlEn) begin
      selPd     = regPd;
      selSingle = regSingleLane;
      selAlign  = regAlign;
      selTest   = regTestEn;
      selCustom = regCustomSel;
    end else begin
      selPd     = pinPd;
      selSingle = pinSingleLane;
      selAlign  = pinAlign;
      selTest   = pinTest;
      selCustom = 1'b0;
    end
    // alignment only matters with two lanes
    selStagger = !selSingle && !selAlign;
  end

  assign lastIdx = curSingle ? LAST_SINGLE : LAST_DUAL;
  assign wordEnd = (bitCnt == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= LAST_SINGLE;
      curSingle  <= 1'b1;
      curStagger <= 1'b0;
      curPd      <= '0;
      clkQ       <= 1'b0;
    end else begin
      clkQ <= ~clkQ;
      if (wordEnd) begin
        bitCnt     <= '0;
        curSingle  <= selSingle;
        curStagger <= selStagger;
        curPd      <= selPd;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign frameHigh = (bitCnt < (curSingle ? HALF_SINGLE : HALF_DUAL));
  assign bitClk    = clkQ;

  always_comb begin
    ctlStrobe.loadWord             = wordEnd;
    ctlStrobe.nextCfg.pd           = selPd;
    ctlStrobe.nextCfg.singleLane   = selSingle;
    ctlStrobe.nextCfg.useTest      = selTest;
    ctlStrobe.nextCfg.useCustom    = selCustom;
    ctlStrobe.curPd                = curPd;
    if (curSingle)       ctlStrobe.curLo = LO_OFF;
    else if (curStagger) ctlStrobe.curLo = LO_DELAYED;
    else                 ctlStrobe.curLo = LO_DIRECT;
  end
endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import adcfmt_pkg::*;
#(
  parameter int                WORD_W    = 12,
  parameter logic [WORD_W-1:0] FIXED_PAT = 12'hA63
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  fmtStrobe_t                     ctlStrobe,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  sampleIn,
  input  logic [NUM_CH-1:0]              rangeIn,
  input  logic [WORD_W-1:0]              customPat,
  output logic [NUM_CH-1:0]              laneHi,
  output logic [NUM_CH-1:0]              laneLo,
  output logic [NUM_CH-1:0]              rangeOut
);
  localparam int LANE_W = WORD_W / 2;
  localparam int STAG   = LANE_W / 2;
  localparam logic [WORD_W-1:0] LSB_CLR = ~WORD_W'(1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [WORD_W-1:0] wordSel;
    logic [LANE_W-1:0] hiLoad;
    logic [LANE_W-1:0] loLoad;
    logic [WORD_W-1:0] hiSh;
    logic [LANE_W-1:0] loSh;
    logic [STAG-1:0]   dly;
    logic              rangeQ;
    logic              loBit;

    // Word source: test word or sample with D0 cleared
    always_comb begin
      if (ctlStrobe.nextCfg.useTest)
        wordSel = ctlStrobe.nextCfg.useCustom ? customPat : FIXED_PAT;
      else
        wordSel = sampleIn[ch] & LSB_CLR;
    end

    // Split into high-lane (D11,D9..) and low-lane (D10,D8..) halves
    always_comb begin
      for (int i = 0; i < LANE_W; i++) begin
        hiLoad[LANE_W-1-i] = wordSel[WORD_W-1-2*i];
        loLoad[LANE_W-1-i] = wordSel[WORD_W-2-2*i];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiSh   <= '0;
        loSh   <= '0;
        dly    <= '0;
        rangeQ <= 1'b0;
      end else begin
        dly <= {dly[STAG-2:0], loSh[LANE_W-1]};
        if (ctlStrobe.loadWord) begin
          if (ctlStrobe.nextCfg.pd[ch]) begin
            hiSh   <= '0;
            loSh   <= '0;
            rangeQ <= 1'b0;
          end else begin
            rangeQ <= rangeIn[ch];
            if (ctlStrobe.nextCfg.singleLane) begin
              hiSh <= wordSel;
              loSh <= '0;
            end else begin
              hiSh <= {hiLoad, {(WORD_W-LANE_W){1'b0}}};
              loSh <= loLoad;
            end
          end
        end else begin
          hiSh <= {hiSh[WORD_W-2:0], 1'b0};
          loSh <= {loSh[LANE_W-2:0], 1'b0};
        end
      end
    end

    always_comb begin
      unique case (ctlStrobe.curLo)
        LO_DIRECT:  loBit = loSh[LANE_W-1];
        LO_DELAYED: loBit = dly[STAG-1];
        default:    loBit = 1'b0;
      endcase
    end

    assign laneHi[ch]   = hiSh[WORD_W-1];
    assign laneLo[ch]   = loBit && !ctlStrobe.curPd[ch];
    assign rangeOut[ch] = rangeQ;
  end
endmodule

// File: rtl/adc_serial_formatter.sv
module adc_serial_formatter
  import adcfmt_pkg::*;
#(
  parameter int                WORD_W    = 12,
  parameter logic [WORD_W-1:0] FIXED_PAT = 12'hA63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] sampleA,
  input  logic              rangeErrA,
  input  logic [WORD_W-1:0] sampleB,
  input  logic              rangeErrB,
  input  logic              serCtlEn,
  input  logic              pinPdA,
  input  logic              pinPdB,
  input  logic              pinSingleLane,
  input  logic              pinAlign,
  input  logic              pinTest,
  input  logic              regPdA,
  input  logic              regPdB,
  input  logic              regSingleLane,
  input  logic              regAlign,
  input  logic              regTestEn,
  input  logic              regCustomSel,
  input  logic [WORD_W-1:0] regCustomPat,
  output logic              laneHiA,
  output logic              laneLoA,
  output logic              laneHiB,
  output logic              laneLoB,
  output logic              bitClkOut,
  output logic              frameOut,
  output logic              rangeOutA,
  output logic              rangeOutB
);
  fmtStrobe_t                    ctlStrobe;
  logic [NUM_CH-1:0]             laneHi;
  logic [NUM_CH-1:0]             laneLo;
  logic [NUM_CH-1:0]             rangeOut;
  logic [NUM_CH-1:0][WORD_W-1:0] sampleVec;

  assign sampleVec = {sampleB, sampleA};

  fmt_control #(.WORD_W(WORD_W)) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .serCtlEn     (serCtlEn),
    .pinPd        ({pinPdB, pinPdA}),
    .pinSingleLane(pinSingleLane),
    .pinAlign     (pinAlign),
    .pinTest      (pinTest),
    .regPd        ({regPdB, regPdA}),
    .regSingleLane(regSingleLane),
    .regAlign     (regAlign),
    .regTestEn    (regTestEn),
    .regCustomSel (regCustomSel),
    .ctlStrobe    (ctlStrobe),
    .bitClk       (bitClkOut),
    .frameHigh    (frameOut)
  );

  fmt_datapath #(.WORD_W(WORD_W), .FIXED_PAT(FIXED_PAT)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctlStrobe(ctlStrobe),
    .sampleIn (sampleVec),
    .rangeIn  ({rangeErrB, rangeErrA}),
    .customPat(regCustomPat),
    .laneHi   (laneHi),
    .laneLo   (laneLo),
    .rangeOut (rangeOut)
  );

  assign laneHiA   = laneHi[0];
  assign laneHiB   = laneHi[1];
  assign laneLoA   = laneLo[0];
  assign laneLoB   = laneLo[1];
  assign rangeOutA = rangeOut[0];
  assign rangeOutB = rangeOut[1];
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker
  import adcfmt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       laneHiA,
  input logic       laneLoA,
  input logic       laneHiB,
  input logic       laneLoB,
  input logic       bitClkOut,
  input logic       frameOut,
  input logic       rangeOutA,
  input logic       rangeOutB,
  input fmtStrobe_t ctlStrobe
);
  // R5
  bit_clock_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bitClkOut != $past(bitClkOut)));

  // R6
  frame_start_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOut) |-> bitClkOut);

  // R10
  pd_a_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.curPd[0] |-> (!laneHiA && !laneLoA && !rangeOutA));

  // R10
  pd_b_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.curPd[1] |-> (!laneHiB && !laneLoB && !rangeOutB));

  // R11
  range_a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rangeOutA) |-> $rose(frameOut));

  // R11
  range_b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rangeOutB) |-> $rose(frameOut));
endmodule

bind adc_serial_formatter fmt_checker i_fmt_checker (
  .clk      (clk),
  .rstN     (rstN),
  .laneHiA  (laneHiA),
  .laneLoA  (laneLoA),
  .laneHiB  (laneHiB),
  .laneLoB  (laneLoB),
  .bitClkOut(bitClkOut),
  .frameOut (frameOut),
  .rangeOutA(rangeOutA),
  .rangeOutB(rangeOutB),
  .ctlStrobe(ctlStrobe)
);

// File: tb/test_adc_serial_formatter.sv
`timescale 1ns/1ps
module test_adc_serial_formatter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic [11:0] sampleA, sampleB, regCustomPat;
  logic rangeErrA, rangeErrB, serCtlEn;
  logic pinPdA, pinPdB, pinSingleLane, pinAlign, pinTest;
  logic regPdA, regPdB, regSingleLane, regAlign, regTestEn, regCustomSel;
  logic laneHiA, laneLoA, laneHiB, laneLoB, bitClkOut, frameOut, rangeOutA, rangeOutB;

  int checks = 0;
  int errors = 0;

  adc_serial_formatter i_adc_serial_formatter (.*);

  typedef struct packed {
    logic single, align, test, rngA, rngB;
    logic [11:0] sA, sB, eA, eB;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'hABC, 12'h555, 12'hABC, 12'h554},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 12'hFFF, 12'h001, 12'hFFE, 12'h000},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h3C7, 12'h8A5, 12'h3C6, 12'h8A4},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 12'h123, 12'h456, 12'hA63, 12'hA63},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000, 12'hFFF, 12'hA63, 12'hA63},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'h7F0, 12'h00F, 12'h7F0, 12'h00E}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Wait until the negedge at which a new word's first bit is visible
  task automatic syncWord();
    logic p;
    p = frameOut;
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      if (frameOut && !p) return;
      p = frameOut;
    end
    check(1'b0, "R6", "no frame start found", 0, 1);
  endtask

  task automatic readWord(input bit dual, input bit stag,
                          output logic [11:0] wA, output logic [11:0] wB,
                          output logic rA, output logic rB,
                          output bit frameOk, output bit loIdle, output bit rngSteady);
    int n, wlen, idx;
    wA = '0; wB = '0; frameOk = 1'b1; loIdle = 1'b1; rngSteady = 1'b1;
    rA = rangeOutA; rB = rangeOutB;
    wlen = dual ? 6 : 12;
    n = dual ? (stag ? 9 : 6) : 12;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (k < wlen) begin
        if (frameOut != (k < wlen / 2)) frameOk = 1'b0;
        if (bitClkOut != (k % 2 == 0)) frameOk = 1'b0;
        if (rangeOutA != rA || rangeOutB != rB) rngSteady = 1'b0;
      end
      if (!dual) begin
        wA[11-k] = laneHiA;
        wB[11-k] = laneHiB;
        if (laneLoA || laneLoB) loIdle = 1'b0;
      end else begin
        if (k < 6) begin
          wA[11-2*k] = laneHiA;
          wB[11-2*k] = laneHiB;
        end
        idx = stag ? k - 3 : k;
        if (idx >= 0 && idx < 6) begin
          wA[10-2*idx] = laneLoA;
          wB[10-2*idx] = laneLoB;
        end
      end
    end
  endtask

  task automatic setIdle();
    serCtlEn = 0; pinPdA = 0; pinPdB = 0; pinSingleLane = 1; pinAlign = 0; pinTest = 0;
    regPdA = 0; regPdB = 0; regSingleLane = 1; regAlign = 0; regTestEn = 0;
    regCustomSel = 0; regCustomPat = 12'h000;
    sampleA = '0; sampleB = '0; rangeErrA = 0; rangeErrB = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] wA, wB;
    logic rA, rB;
    bit fOk, loI, rS;
    string req;

    setIdle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({laneHiA, laneLoA, laneHiB, laneLoB, bitClkOut, frameOut, rangeOutA, rangeOutB} == 8'h00,
          "R1", "outputs in reset",
          {laneHiA, laneLoA, laneHiB, laneLoB, bitClkOut, frameOut, rangeOutA, rangeOutB}, 0);
    rstN = 1'b1;

    // Table of vectors, direct pin control
    foreach (VECS[i]) begin
      pinSingleLane = VECS[i].single; pinAlign = VECS[i].align; pinTest = VECS[i].test;
      sampleA = VECS[i].sA; sampleB = VECS[i].sB;
      rangeErrA = VECS[i].rngA; rangeErrB = VECS[i].rngB;
      syncWord(); syncWord();
      readWord(!VECS[i].single, !VECS[i].single && !VECS[i].align, wA, wB, rA, rB, fOk, loI, rS);
      req = VECS[i].test ? "R7" : (VECS[i].single ? "R2" : (VECS[i].align ? "R3" : "R4"));
      check(wA == VECS[i].eA, req, "word A", wA, VECS[i].eA);
      check(wB == VECS[i].eB, req, "word B", wB, VECS[i].eB);
      check(rA == VECS[i].rngA && rB == VECS[i].rngB && rS, "R11", "range flags",
            {rA, rB}, {VECS[i].rngA, VECS[i].rngB});
      check(fOk, "R5", "bit clock and R6 frame timing", fOk, 1);
      if (VECS[i].single) check(loI, "R4", "low lane idle in single mode (R2)", loI, 1);
    end

    // R8 / R9: registers rule, pins ignored (pins ask for single, A powered down)
    serCtlEn = 1; pinSingleLane = 1; pinAlign = 0; pinPdA = 1; pinTest = 0;
    regSingleLane = 0; regAlign = 1; regTestEn = 1; regCustomSel = 1; regCustomPat = 12'h5A5;
    syncWord(); syncWord();
    readWord(1, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(wA == 12'h5A5, "R8", "custom word A", wA, 12'h5A5);
    check(wB == 12'h5A5, "R9", "custom word B, pins ignored", wB, 12'h5A5);
    check(fOk, "R9", "two-lane timing despite single-lane pin", fOk, 1);

    // R8: fixed pattern through registers
    regCustomSel = 0;
    syncWord(); syncWord();
    readWord(1, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(wA == 12'hA63 && wB == 12'hA63, "R8", "fixed word via register", wA, 12'hA63);

    // R8 / R9: register power-down of B, test pin ignored
    regTestEn = 0; regPdB = 1; pinTest = 1; pinPdB = 0;
    sampleA = 12'h9F3; sampleB = 12'hFFF; rangeErrA = 1; rangeErrB = 1;
    syncWord(); syncWord();
    readWord(1, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(wA == 12'h9F2, "R9", "A sample with test pin ignored", wA, 12'h9F2);
    check(wB == 12'h000 && rB == 0, "R8", "B powered down by register", {wB, rB}, 0);
    check(rA == 1, "R11", "A range flag", rA, 1);

    // R10: pin power-down of A in single-lane mode
    serCtlEn = 0; regPdB = 0; pinTest = 0; pinPdA = 1; pinSingleLane = 1; pinAlign = 0;
    sampleB = 12'h6D9;
    syncWord(); syncWord();
    readWord(0, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(wA == 12'h000 && rA == 0 && loI, "R10", "A powered down quiet", {wA, rA}, 0);
    check(wB == 12'h6D8 && rB == 1, "R10", "B unaffected", {wB, rB}, {12'h6D8, 1'b1});

    // R9: pin power-down ignored when registers rule
    serCtlEn = 1; regPdA = 0; regSingleLane = 1; regAlign = 0; regTestEn = 0;
    syncWord(); syncWord();
    readWord(0, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(wA == 12'h9F2 && rA == 1, "R9", "A active despite pin power-down", {wA, rA}, {12'h9F2, 1'b1});

    // R12: change mid-word, takes effect next word
    serCtlEn = 0; pinPdA = 0; sampleA = 12'h111; rangeErrA = 1;
    syncWord(); syncWord();
    sampleA = 12'hEEF; rangeErrA = 0;
    readWord(0, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(wA == 12'h110 && rA == 1 && rS, "R12", "current word unchanged", {wA, rA}, {12'h110, 1'b1});
    syncWord();
    readWord(0, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(wA == 12'hEEE && rA == 0, "R12", "next word updated", {wA, rA}, {12'hEEE, 1'b0});

    // R12: mode change mid-word keeps the current single-lane word length
    syncWord();
    pinSingleLane = 0; pinAlign = 1;
    readWord(0, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(fOk && wA == 12'hEEE, "R12", "single word completes after mode change", wA, 12'hEEE);
    syncWord();
    readWord(1, 0, wA, wB, rA, rB, fOk, loI, rS);
    check(fOk && wA == 12'hEEE, "R3", "two-lane word after mode change", wA, 12'hEEE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule